// File: doc/BRIEF.md
# Cross-Domain Mailbox Word with Pending Flag

This block passes a single 36-bit word from a writer running on `a_clk` to a reader running on `b_clk`. The word travels beside any streaming data path, not through it. The writer posts the word with a qualified write strobe. The reader sees an active-low flag, `b_mbx_full_n`, that goes low once the word has arrived. A qualified read copies the word to the reader's output register and sends the flag back high.

The two clocks may be fully unrelated. Each event crosses the boundary as a change of level on a toggle line, and a chain of flip-flops synchronizes it on the far side. The writer holds a pending state of its own, and writes that come in while the pending state is set are dropped. The stored word therefore cannot change while the other domain may still sample it. For two-way traffic, instantiate the block twice with the clocks swapped.

Top module: `mbx_xdomain`

## Requirements
- R1: While `rst_n` is low and after reset is released, `b_mbx_full_n` is 1, `b_dout` is all zeros and the writer is free.
- R2: A write is taken on a rising `a_clk` edge only when `a_cs_n`=0, `a_wr_sel`=1, `a_en`=1 and `a_mbx_sel`=1. Any other combination leaves the flag and the stored word untouched.
- R3: With `SYNC_STAGES`=2, `b_mbx_full_n` goes low at the third rising `b_clk` edge after the `a_clk` edge that took the write, and not before.
- R4: A read is taken on a rising `b_clk` edge only when `b_cs_n`=0, `b_wr_sel`=0, `b_en`=1, `b_mbx_sel`=1 and the flag is low. At that edge `b_dout` loads the stored word and `b_mbx_full_n` returns to 1.
- R5: A read strobe while `b_mbx_full_n` is 1 changes neither `b_dout` nor the flag.
- R6: From a taken write until the third rising `a_clk` edge after the read that clears the flag, further writes are dropped, and the stored word does not change. A write that arrives on that third edge is also dropped.
- R7: `b_dout` keeps its value on every `b_clk` edge that does not take a read.
- R8: All 36 bits of the written word reach `b_dout` unchanged. This holds for all-ones, all-zeros, alternating and single-bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_clk | input | 1 | Writer clock |
| a_cs_n | input | 1 | Writer select, active low |
| a_wr_sel | input | 1 | Writer direction, 1 means write |
| a_en | input | 1 | Writer enable |
| a_mbx_sel | input | 1 | Writer targets the mailbox when 1 |
| a_din | input | 36 | Word to post |
| b_clk | input | 1 | Reader clock |
| b_cs_n | input | 1 | Reader select, active low |
| b_wr_sel | input | 1 | Reader direction, 0 means read |
| b_en | input | 1 | Reader enable |
| b_mbx_sel | input | 1 | Reader targets the mailbox when 1 |
| b_dout | output | 36 | Last word taken by a read |
| b_mbx_full_n | output | 1 | Low while a posted word waits to be read |

## Verification
The write becomes visible on the flag at the third reader edge after the writer edge that took it. A taken read updates `b_dout` and the flag at the same reader edge. The writer is free again at the third writer edge after that read. The bench keeps these distances as edge countdowns in a behavioural model and compares both outputs at every falling `b_clk` edge, halfway between the reader's sampling points. The directed latency check counts reader edges from the writer edge itself, so it checks the flag just before and just after the third edge. The two clocks are set so that their rising edges never coincide, which makes every count exact.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned MBX_DATA_W = 36;

  typedef struct packed {
    logic cs_n;
    logic wr_sel;
    logic en;
    logic sel;
  } mbx_ctl_t;

  // Decode of a mailbox write strobe on the writer side.
  function automatic logic mbx_wr_hit(input mbx_ctl_t c);
    return !c.cs_n && c.wr_sel && c.en && c.sel;
  endfunction

  // Decode of a mailbox read strobe on the reader side.
  function automatic logic mbx_rd_hit(input mbx_ctl_t c);
    return !c.cs_n && !c.wr_sel && c.en && c.sel;
  endfunction

endpackage

// File: rtl/mbx_tgl_sync.sv
module mbx_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
  import mbx_pkg::*;
#(
  parameter int unsigned W      = MBX_DATA_W,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mbx_ctl_t     ctl,
  input  logic [W-1:0] din,
  input  logic         ack_tgl_async,
  output logic         req_tgl,
  output logic [W-1:0] mail_q,
  output logic         pending,
  output logic         wr_take
);

  logic ack_sync;
  logic ack_seen;
  logic ack_evt;

  mbx_tgl_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_tgl_async),
    .q    (ack_sync)
  );

  assign ack_evt = ack_sync ^ ack_seen;
  assign wr_take = mbx_wr_hit(ctl) && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl  <= 1'b0;
      mail_q   <= '0;
      pending  <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      ack_seen <= ack_sync;
      if (wr_take) begin
        mail_q  <= din;
        req_tgl <= ~req_tgl;
        pending <= 1'b1;
      end else if (ack_evt) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side
  import mbx_pkg::*;
#(
  parameter int unsigned W      = MBX_DATA_W,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mbx_ctl_t     ctl,
  input  logic         req_tgl_async,
  input  logic [W-1:0] mail_q,
  output logic         ack_tgl,
  output logic [W-1:0] dout,
  output logic         full_n,
  output logic         rd_take
);

  logic req_sync;
  logic req_seen;
  logic req_evt;

  mbx_tgl_sync #(.STAGES(STAGES)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_tgl_async),
    .q    (req_sync)
  );

  assign req_evt = req_sync ^ req_seen;
  assign rd_take = mbx_rd_hit(ctl) && !full_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl  <= 1'b0;
      dout     <= '0;
      full_n   <= 1'b1;
      req_seen <= 1'b0;
    end else begin
      req_seen <= req_sync;
      if (rd_take) begin
        dout    <= mail_q;
        full_n  <= 1'b1;
        ack_tgl <= ~ack_tgl;
      end else if (req_evt) begin
        full_n <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mbx_xdomain.sv
module mbx_xdomain
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_cs_n,
  input  logic              a_wr_sel,
  input  logic              a_en,
  input  logic              a_mbx_sel,
  input  logic [DATA_W-1:0] a_din,
  input  logic              b_clk,
  input  logic              b_cs_n,
  input  logic              b_wr_sel,
  input  logic              b_en,
  input  logic              b_mbx_sel,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_mbx_full_n
);

  mbx_ctl_t          a_ctl;
  mbx_ctl_t          b_ctl;
  logic              req_tgl;
  logic              ack_tgl;
  logic [DATA_W-1:0] a_mail_q;
  logic              a_pending;
  logic              a_wr_take;
  logic              b_rd_take;

  assign a_ctl = '{cs_n: a_cs_n, wr_sel: a_wr_sel, en: a_en, sel: a_mbx_sel};
  assign b_ctl = '{cs_n: b_cs_n, wr_sel: b_wr_sel, en: b_en, sel: b_mbx_sel};

  mbx_wr_side #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_wr (
    .clk          (a_clk),
    .rst_n        (rst_n),
    .ctl          (a_ctl),
    .din          (a_din),
    .ack_tgl_async(ack_tgl),
    .req_tgl      (req_tgl),
    .mail_q       (a_mail_q),
    .pending      (a_pending),
    .wr_take      (a_wr_take)
  );

  mbx_rd_side #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_rd (
    .clk          (b_clk),
    .rst_n        (rst_n),
    .ctl          (b_ctl),
    .req_tgl_async(req_tgl),
    .mail_q       (a_mail_q),
    .ack_tgl      (ack_tgl),
    .dout         (b_dout),
    .full_n       (b_mbx_full_n),
    .rd_take      (b_rd_take)
  );

endmodule

// File: rtl/mbx_xdomain_chk.sv
module mbx_xdomain_chk #(
  parameter int unsigned W = 36
) (
  input logic         rst_n,
  input logic         a_clk,
  input logic         b_clk,
  input logic         wr_take,
  input logic         pending,
  input logic [W-1:0] mail_q,
  input logic         rd_take,
  input logic         full_n,
  input logic [W-1:0] dout
);

  // R6: a taken write leaves the writer busy on the next edge
  p_write_pends_r6: assert property (@(posedge a_clk) disable iff (!rst_n)
    wr_take |=> pending);

  // R6: the stored word does not move while the writer is busy
  p_mail_hold_r6: assert property (@(posedge a_clk) disable iff (!rst_n)
    pending |=> $stable(mail_q));

  // R3: the flag can only fall while a posted word is outstanding
  p_flag_fall_pending_r3: assert property (@(posedge b_clk) disable iff (!rst_n)
    $fell(full_n) |-> pending);

  // R4: a taken read returns the flag high
  p_read_sets_flag_r4: assert property (@(posedge b_clk) disable iff (!rst_n)
    rd_take |=> full_n);

  // R7: the output holds when no read is taken
  p_idle_dout_stable_r7: assert property (@(posedge b_clk) disable iff (!rst_n)
    !rd_take |=> $stable(dout));

  // R4: a taken read copies the posted word
  p_read_copies_word_r4: assert property (@(posedge b_clk) disable iff (!rst_n)
    rd_take |=> (dout == $past(mail_q)));

endmodule

bind mbx_xdomain mbx_xdomain_chk #(.W(DATA_W)) u_chk (
  .rst_n  (rst_n),
  .a_clk  (a_clk),
  .b_clk  (b_clk),
  .wr_take(a_wr_take),
  .pending(a_pending),
  .mail_q (a_mail_q),
  .rd_take(b_rd_take),
  .full_n (b_mbx_full_n),
  .dout   (b_dout)
);

// File: tb/sim_mbx_xdomain.sv
module sim_mbx_xdomain;

  localparam int W   = 36;
  localparam int LAT = 3;  // two synchronizer stages plus the flag register

  logic         rst_n;
  logic         a_clk, b_clk;
  logic         a_cs_n, a_wr_sel, a_en, a_mbx_sel;
  logic [W-1:0] a_din;
  logic         b_cs_n, b_wr_sel, b_en, b_mbx_sel;
  logic [W-1:0] b_dout;
  logic         b_mbx_full_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mbx_xdomain u0 (
    .rst_n       (rst_n),
    .a_clk       (a_clk),
    .a_cs_n      (a_cs_n),
    .a_wr_sel    (a_wr_sel),
    .a_en        (a_en),
    .a_mbx_sel   (a_mbx_sel),
    .a_din       (a_din),
    .b_clk       (b_clk),
    .b_cs_n      (b_cs_n),
    .b_wr_sel    (b_wr_sel),
    .b_en        (b_en),
    .b_mbx_sel   (b_mbx_sel),
    .b_dout      (b_dout),
    .b_mbx_full_n(b_mbx_full_n)
  );

  // Reader clock is 100 MHz with rising edges at even ns; writer rising edges are at odd ns.
  initial begin b_clk = 1'b1; forever #5 b_clk = ~b_clk; end
  initial begin a_clk = 1'b0; forever #7 a_clk = ~a_clk; end

  // ---------------- reference model ----------------
  bit           m_busy;
  int           a_cd, b_cd;
  logic [W-1:0] m_mail, m_dout;
  logic         m_flag_n;

  function automatic bit want_write(logic cs_n, logic dir, logic en, logic sel);
    return (cs_n === 1'b0) && (dir === 1'b1) && (en === 1'b1) && (sel === 1'b1);
  endfunction

  function automatic bit want_read(logic cs_n, logic dir, logic en, logic sel);
    return (cs_n === 1'b0) && (dir === 1'b0) && (en === 1'b1) && (sel === 1'b1);
  endfunction

  always @(posedge a_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; a_cd = 0; m_mail = '0;
    end else begin
      bit take;
      take = want_write(a_cs_n, a_wr_sel, a_en, a_mbx_sel) && !m_busy;
      if (a_cd > 0) begin
        a_cd = a_cd - 1;
        if (a_cd == 0) m_busy = 0;
      end
      if (take) begin
        m_mail = a_din; m_busy = 1; b_cd = LAT;
      end
    end
  end

  always @(posedge b_clk or negedge rst_n) begin
    if (!rst_n) begin
      b_cd = 0; m_dout = '0; m_flag_n = 1'b1;
    end else if (want_read(b_cs_n, b_wr_sel, b_en, b_mbx_sel) && m_flag_n == 1'b0) begin
      m_dout = m_mail; m_flag_n = 1'b1; a_cd = LAT;
    end else if (b_cd > 0) begin
      b_cd = b_cd - 1;
      if (b_cd == 0) m_flag_n = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, half a reader period after each edge
  always @(negedge b_clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R3 R6 flag vs model", W'(b_mbx_full_n), W'(m_flag_n));
      chk("R4 R7 data vs model", b_dout, m_dout);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic a_idle();
    a_cs_n = 1'b1; a_wr_sel = 1'b0; a_en = 1'b0; a_mbx_sel = 1'b0;
  endtask

  task automatic b_idle();
    b_cs_n = 1'b1; b_wr_sel = 1'b1; b_en = 1'b0; b_mbx_sel = 1'b0;
  endtask

  task automatic a_drive(input logic cs_n, input logic dir, input logic en,
                         input logic sel, input logic [W-1:0] d);
    @(negedge a_clk);
    a_cs_n = cs_n; a_wr_sel = dir; a_en = en; a_mbx_sel = sel; a_din = d;
    @(posedge a_clk);
    @(negedge a_clk);
    a_idle();
  endtask

  task automatic b_drive(input logic cs_n, input logic dir, input logic en, input logic sel);
    @(negedge b_clk);
    b_cs_n = cs_n; b_wr_sel = dir; b_en = en; b_mbx_sel = sel;
    @(posedge b_clk);
    @(negedge b_clk);
    b_idle();
  endtask

  task automatic wait_full();
    while (b_mbx_full_n !== 1'b0) @(negedge b_clk);
  endtask

  task automatic write_timed(input logic [W-1:0] d);
    @(negedge a_clk);
    a_cs_n = 1'b0; a_wr_sel = 1'b1; a_en = 1'b1; a_mbx_sel = 1'b1; a_din = d;
    @(posedge a_clk);
    fork
      begin @(negedge a_clk); a_idle(); end
    join_none
    @(posedge b_clk);
    @(posedge b_clk);
    @(negedge b_clk);
    chk("R3 flag still high after two reader edges", W'(b_mbx_full_n), W'(1'b1));
    @(posedge b_clk);
    @(negedge b_clk);
    chk("R3 flag low at third reader edge", W'(b_mbx_full_n), W'(1'b0));
  endtask

  localparam logic [W-1:0] WORD1 = 36'h9_A5C3_0F7E;
  localparam logic [W-1:0] WORD2 = 36'h1_2345_6789;
  localparam logic [W-1:0] WORD3 = 36'hE_DCBA_9876;

  initial begin
    rst_n = 1'b0;
    a_idle(); b_idle(); a_din = '0;
    #103;
    chk("R1 flag during reset", W'(b_mbx_full_n), W'(1'b1));
    rst_n = 1'b1;
    @(negedge b_clk);
    chk("R1 flag after reset", W'(b_mbx_full_n), W'(1'b1));
    chk("R1 dout after reset", b_dout, '0);

    // R2: strobes that are not a mailbox write
    a_drive(1'b1, 1'b1, 1'b1, 1'b1, 36'h0_0000_0011);
    a_drive(1'b0, 1'b0, 1'b1, 1'b1, 36'h0_0000_0022);
    a_drive(1'b0, 1'b1, 1'b0, 1'b1, 36'h0_0000_0033);
    a_drive(1'b0, 1'b1, 1'b1, 1'b0, 36'h0_0000_0044);
    repeat (8) @(negedge b_clk);
    chk("R2 flag unaffected by non-write strobes", W'(b_mbx_full_n), W'(1'b1));
    // R5: read while empty
    b_drive(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5 dout unchanged by read when empty", b_dout, '0);
    chk("R5 flag unchanged by read when empty", W'(b_mbx_full_n), W'(1'b1));

    // R3: exact arrival latency
    write_timed(WORD1);

    // R6: second write while pending is dropped
    a_drive(1'b0, 1'b1, 1'b1, 1'b1, WORD2);
    b_drive(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 read returns posted word", b_dout, WORD1);
    chk("R4 read raises flag", W'(b_mbx_full_n), W'(1'b1));
    repeat (10) @(negedge b_clk);
    chk("R6 dropped write never arrives", W'(b_mbx_full_n), W'(1'b1));

    // R5 / R7: a further read with flag high keeps the output
    b_drive(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5 R7 dout holds on read when empty", b_dout, WORD1);

    // R4: non-decoded reader strobe while mail is waiting
    repeat (6) @(negedge a_clk);
    a_drive(1'b0, 1'b1, 1'b1, 1'b1, WORD3);
    wait_full();
    b_drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 non-mailbox read leaves flag low", W'(b_mbx_full_n), W'(1'b0));
    chk("R4 R7 non-mailbox read leaves dout", b_dout, WORD1);
    b_drive(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 read returns third word", b_dout, WORD3);

    // R8: bit patterns across the full width
    begin
      logic [W-1:0] pats [5];
      pats[0] = '1;
      pats[1] = '0;
      pats[2] = {(W/2){2'b01}};
      pats[3] = {(W/2){2'b10}};
      pats[4] = W'(1) << (W-1);
      for (int i = 0; i < 5; i++) begin
        repeat (6) @(negedge a_clk);
        a_drive(1'b0, 1'b1, 1'b1, 1'b1, pats[i]);
        wait_full();
        b_drive(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R8 full-width pattern", b_dout, pats[i]);
      end
    end

    // Mixed traffic on both ports, checked against the model every reader cycle (R6 window edges)
    fork
      begin
        for (int i = 0; i < 700; i++) begin
          @(negedge a_clk);
          a_cs_n    = ($urandom_range(0, 4) == 0);
          a_wr_sel  = ($urandom_range(0, 5) != 0);
          a_en      = ($urandom_range(0, 4) != 0);
          a_mbx_sel = ($urandom_range(0, 5) != 0);
          a_din     = W'({$urandom(), $urandom()});
        end
        @(negedge a_clk);
        a_idle();
      end
      begin
        for (int i = 0; i < 900; i++) begin
          @(negedge b_clk);
          b_cs_n    = ($urandom_range(0, 4) == 0);
          b_wr_sel  = ($urandom_range(0, 3) == 0);
          b_en      = ($urandom_range(0, 2) != 0);
          b_mbx_sel = ($urandom_range(0, 5) != 0);
        end
        @(negedge b_clk);
        b_idle();
      end
    join

    repeat (20) @(negedge b_clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule